// File: doc/BRIEF.md
# Command Sequence Write Guard

This block sits between the host bus and the array-write path of a byte-wide nonvolatile memory model. It sees every write (address and data) and splits them into two kinds. Some writes are steps of a command sequence, and the block keeps those for itself. Other writes are ordinary page bytes, and the block either grants them or drops them.

The block recognises two command sequences:

- **Three-byte sequence.** This one sequence serves both to arm protection and to unlock writing. The first time it completes, it sets a sticky protection flag. Each later completion opens write permission for exactly one page-load session. An external timer block ends that session with a pulse, and the device is locked again with no further command.
- **Six-byte sequence.** This one starts a chip erase. Write intake then stalls until the erase timer reports completion.

The page buffer, the timers and the array storage are separate blocks.

Write intake is a valid/ready stream. A write is accepted only in a cycle where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the source must keep `wr_valid`, `wr_addr` and `wr_data` stable. `wr_ready` is low only while an erase is running.

The permit output is a one-cycle pulse with no back-pressure. The array side must take it in the cycle it appears.

Top module: `cmdseq_guard`

## Requirements
- R1: After reset, `prot_on`, `page_open`, `permit_valid` and `erase_start` are 0 and `wr_ready` is 1.
- R2: The unlock sequence is, in order: AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h. When it completes with protection clear, `prot_on` becomes 1 one cycle after the third accepted write, and `page_open` stays 0. `prot_on` never returns to 0 until reset.
- R3: When the unlock sequence completes with `prot_on` already 1, `page_open` becomes 1 one cycle after the third accepted write.
- R4: An accepted write that is not kept as a command step is granted when `prot_on` is 0 or `page_open` is 1. A granted write raises `permit_valid` for one cycle, in the cycle after acceptance, with that write's address and data on `permit_addr` and `permit_data`.
- R5: A one-cycle `session_end` pulse clears `page_open` one cycle later and leaves `prot_on` at 1. Later non-command writes produce no permit.
- R6: When `prot_on` is 1 and `page_open` is 0, a non-command write is discarded and `permit_valid` stays 0.
- R7: A write that does not match the expected next step sends the sequencer back to idle. The exception is a write of AAh to 5555h, which restarts matching at step one.
- R8: The erase sequence is, in order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. Its completion raises `erase_start` for exactly one cycle, one cycle after the sixth accepted write, and does not change `prot_on` or `page_open`.
- R9: `wr_ready` is 0 from the cycle in which `erase_start` is high until the cycle after an `erase_done` pulse. A write held valid during that window is not accepted and produces no permit. It is accepted once `wr_ready` returns.
- R10: When `session_end` falls in the same cycle as an accepted write, the write is discarded. When it falls in the same cycle as an unlock completion, `page_open` is 1 afterwards.
- R11: Command matching uses only the low 15 address bits. Higher address bits are ignored for matching, but a permitted write carries its full 17-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Write intake ready (low while an erase runs) |
| wr_addr | input | 17 | Write byte address |
| wr_data | input | 8 | Write data byte |
| session_end | input | 1 | Pulse: the open page-load session has finished |
| erase_done | input | 1 | Pulse: the erase cycle has finished |
| permit_valid | output | 1 | Pulse: the write on permit_addr/permit_data may go to the page buffer |
| permit_addr | output | 17 | Address of the granted write |
| permit_data | output | 8 | Data of the granted write |
| erase_start | output | 1 | Pulse: start the chip-erase cycle |
| prot_on | output | 1 | Protection flag has been armed |
| page_open | output | 1 | A single-page write session is open |

## Verification
The closing of a session can land in the same cycle as other activity. The bench drives a `session_end` pulse in the very cycle that a page byte is accepted, and again in the cycle that a third unlock byte is accepted. A behavioural model predicts, clock by clock, that the byte is dropped in the first case and that the session is reopened in the second. A held write under erase back-pressure is also compared every cycle, to confirm that it is taken only after `erase_done`.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_K1   = 3'd1,
    SQ_K2   = 3'd2,
    SQ_E3   = 3'd3,
    SQ_E4   = 3'd4,
    SQ_E5   = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic lead;    // AAh at the first command address
    logic second;  // 55h at the second command address
    logic unlk;    // A0h at the first command address
    logic ers_pre; // 80h at the first command address
    logic ers_fin; // 10h at the first command address
  } step_hit_t;

  localparam logic [15:0] CMD_LOC_P = 16'h5555;
  localparam logic [15:0] CMD_LOC_Q = 16'h2AAA;
  localparam logic [7:0]  CODE_LEAD = 8'hAA;
  localparam logic [7:0]  CODE_SEC  = 8'h55;
  localparam logic [7:0]  CODE_UNLK = 8'hA0;
  localparam logic [7:0]  CODE_EPRE = 8'h80;
  localparam logic [7:0]  CODE_EFIN = 8'h10;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
#(
  parameter int CMP_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output step_hit_t         hit
);
  localparam logic [CMP_W-1:0]  LOC_P = CMP_W'(CMD_LOC_P);
  localparam logic [CMP_W-1:0]  LOC_Q = CMP_W'(CMD_LOC_Q);
  localparam int NCODE = 5;

  logic at_p, at_q;
  logic [NCODE-1:0] code_eq;
  logic [DATA_W-1:0] codes [NCODE];

  assign at_p = (addr_lo == LOC_P);
  assign at_q = (addr_lo == LOC_Q);

  assign codes[0] = DATA_W'(CODE_LEAD);
  assign codes[1] = DATA_W'(CODE_SEC);
  assign codes[2] = DATA_W'(CODE_UNLK);
  assign codes[3] = DATA_W'(CODE_EPRE);
  assign codes[4] = DATA_W'(CODE_EFIN);

  for (genvar gi = 0; gi < NCODE; gi++) begin : g_code
    assign code_eq[gi] = (data == codes[gi]);
  end

  always_comb begin
    hit.lead    = at_p & code_eq[0];
    hit.second  = at_q & code_eq[1];
    hit.unlk    = at_p & code_eq[2];
    hit.ers_pre = at_p & code_eq[3];
    hit.ers_fin = at_p & code_eq[4];
  end
endmodule

// File: rtl/cmdseq_track.sv
module cmdseq_track
  import cmdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc,
  input  step_hit_t hit,
  output logic      consumed,
  output logic      unlock_evt,
  output logic      erase_evt,
  output logic      is_idle
);
  seq_state_e st_q, st_d;
  logic took;

  always_comb begin
    st_d       = SQ_IDLE;
    took       = 1'b0;
    unlock_evt = 1'b0;
    erase_evt  = 1'b0;
    case (st_q)
      SQ_IDLE: if (hit.lead) begin st_d = SQ_K1; took = 1'b1; end
      SQ_K1: begin
        if (hit.second)    begin st_d = SQ_K2; took = 1'b1; end
        else if (hit.lead) begin st_d = SQ_K1; took = 1'b1; end
      end
      SQ_K2: begin
        if (hit.unlk)         begin st_d = SQ_IDLE; took = 1'b1; unlock_evt = 1'b1; end
        else if (hit.ers_pre) begin st_d = SQ_E3;   took = 1'b1; end
        else if (hit.lead)    begin st_d = SQ_K1;   took = 1'b1; end
      end
      SQ_E3: if (hit.lead) begin st_d = SQ_E4; took = 1'b1; end
      SQ_E4: begin
        if (hit.second)    begin st_d = SQ_E5; took = 1'b1; end
        else if (hit.lead) begin st_d = SQ_K1; took = 1'b1; end
      end
      SQ_E5: begin
        if (hit.ers_fin)   begin st_d = SQ_IDLE; took = 1'b1; erase_evt = 1'b1; end
        else if (hit.lead) begin st_d = SQ_K1;   took = 1'b1; end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (!acc) begin
      st_d       = st_q;
      took       = 1'b0;
      unlock_evt = 1'b0;
      erase_evt  = 1'b0;
    end
  end

  assign consumed = took;
  assign is_idle  = (st_q == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R7: a non-matching, non-restart write always lands in idle
  assert_mismatch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !took) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/cmdseq_lock.sv
module cmdseq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic consumed,
  input  logic unlock_evt,
  input  logic erase_evt,
  input  logic session_end,
  input  logic erase_done,
  output logic grant,
  output logic prot_q,
  output logic sess_q,
  output logic busy_q,
  output logic erase_go_q
);
  logic sess_live;

  assign sess_live = sess_q && !session_end;
  assign grant     = acc && !consumed && (!prot_q || sess_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= 1'b0;
      sess_q     <= 1'b0;
      busy_q     <= 1'b0;
      erase_go_q <= 1'b0;
    end else begin
      prot_q     <= prot_q | unlock_evt;
      erase_go_q <= erase_evt;
      if (unlock_evt && prot_q) sess_q <= 1'b1;
      else if (session_end)     sess_q <= 1'b0;
      if (erase_evt)       busy_q <= 1'b1;
      else if (erase_done) busy_q <= 1'b0;
    end
  end

  assert_prot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prot_q |=> prot_q);
  assert_session_needs_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sess_q |-> prot_q);
endmodule

// File: rtl/cmdseq_guard.sv
module cmdseq_guard
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              session_end,
  input  logic              erase_done,
  output logic              permit_valid,
  output logic [ADDR_W-1:0] permit_addr,
  output logic [DATA_W-1:0] permit_data,
  output logic              erase_start,
  output logic              prot_on,
  output logic              page_open
);
  step_hit_t hit;
  logic acc, consumed, unlock_evt, erase_evt, seq_idle;
  logic grant, prot_q, sess_q, busy_q, erase_go_q;
  logic pv_q;
  logic [ADDR_W-1:0] pa_q;
  logic [DATA_W-1:0] pd_q;

  assign wr_ready = !busy_q;
  assign acc      = wr_valid && wr_ready;

  cmdseq_decode #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_dec (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .hit     (hit)
  );

  cmdseq_track u_trk (
    .clk, .rst_n, .acc, .hit,
    .consumed, .unlock_evt, .erase_evt, .is_idle(seq_idle)
  );

  cmdseq_lock u_lck (
    .clk, .rst_n, .acc, .consumed, .unlock_evt, .erase_evt,
    .session_end, .erase_done,
    .grant, .prot_q, .sess_q, .busy_q, .erase_go_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pa_q <= '0;
      pd_q <= '0;
    end else begin
      pv_q <= grant;
      if (grant) begin
        pa_q <= wr_addr;
        pd_q <= wr_data;
      end
    end
  end

  assign permit_valid = pv_q;
  assign permit_addr  = pa_q;
  assign permit_data  = pd_q;
  assign erase_start  = erase_go_q;
  assign prot_on      = prot_q;
  assign page_open    = sess_q;

  assert_permit_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    permit_valid |-> $past(acc));
  assert_erase_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !wr_ready);
  assert_busy_seq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> seq_idle);
endmodule

// File: tb/cmdseq_guard_bench.sv
`timescale 1ns/1ps
module cmdseq_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic session_end = 1'b0;
  logic erase_done = 1'b0;
  logic wr_ready, permit_valid, erase_start, prot_on, page_open;
  logic [16:0] permit_addr;
  logic [7:0]  permit_data;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmdseq_guard u_cmdseq_guard (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .session_end, .erase_done, .permit_valid, .permit_addr, .permit_data,
    .erase_start, .prot_on, .page_open
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_prot = 0, m_sess = 0, m_busy = 0, m_pv = 0, m_es = 0;
  int m_k = 0;
  logic [16:0] m_pa = '0;
  logic [7:0]  m_pd = '0;

  function automatic bit is_step(input logic [16:0] a, input logic [7:0] d,
                                 input logic [14:0] ea, input logic [7:0] ed);
    return (a[14:0] == ea) && (d == ed);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prot = 0; m_sess = 0; m_busy = 0; m_pv = 0; m_es = 0; m_k = 0;
      m_pa = '0; m_pd = '0;
    end else begin
      bit acc, cons, unl, ers, fwd, lead;
      int nk;
      acc = wr_valid && !m_busy;
      lead = is_step(wr_addr, wr_data, 15'h5555, 8'hAA);
      cons = 0; unl = 0; ers = 0; nk = m_k;
      if (acc) begin
        nk = 0;
        if (m_k == 0 || m_k == 3) begin
          if (lead) begin nk = m_k + 1; cons = 1; end
        end else if (m_k == 1 || m_k == 4) begin
          if (is_step(wr_addr, wr_data, 15'h2AAA, 8'h55)) begin nk = m_k + 1; cons = 1; end
        end else if (m_k == 2) begin
          if (is_step(wr_addr, wr_data, 15'h5555, 8'hA0)) begin nk = 0; cons = 1; unl = 1; end
          else if (is_step(wr_addr, wr_data, 15'h5555, 8'h80)) begin nk = 3; cons = 1; end
        end else if (m_k == 5) begin
          if (is_step(wr_addr, wr_data, 15'h5555, 8'h10)) begin nk = 0; cons = 1; ers = 1; end
        end
        if (!cons && lead) begin nk = 1; cons = 1; end
      end
      fwd = acc && !cons && (!m_prot || (m_sess && !session_end));
      m_pv = fwd;
      if (fwd) begin m_pa = wr_addr; m_pd = wr_data; end
      m_es = ers;
      if (ers) m_busy = 1; else if (erase_done) m_busy = 0;
      if (unl && m_prot) m_sess = 1; else if (session_end) m_sess = 0;
      if (unl) m_prot = 1;
      m_k = nk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready", {31'b0, wr_ready}, {31'b0, !m_busy});
      chk("R4 permit_valid", {31'b0, permit_valid}, {31'b0, m_pv});
      if (m_pv) begin
        chk("R11 permit_addr", {15'b0, permit_addr}, {15'b0, m_pa});
        chk("R4 permit_data", {24'b0, permit_data}, {24'b0, m_pd});
      end
      chk("R8 erase_start", {31'b0, erase_start}, {31'b0, m_es});
      chk("R2 prot_on", {31'b0, prot_on}, {31'b0, m_prot});
      chk("R3 page_open", {31'b0, page_open}, {31'b0, m_sess});
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic put(input logic [16:0] a, input logic [7:0] d, input bit se = 0);
    bit ok;
    wr_valid = 1; wr_addr = a; wr_data = d; session_end = se;
    forever begin
      ok = wr_ready;
      @(negedge clk);
      session_end = 0;
      if (ok) break;
    end
    wr_valid = 0;
  endtask

  task automatic unlock(input logic [16:0] hi = 17'h0);
    put(hi | 17'h05555, 8'hAA);
    put(hi | 17'h02AAA, 8'h55);
    put(hi | 17'h05555, 8'hA0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 prot", {31'b0, prot_on}, 0);
    chk("R1 page", {31'b0, page_open}, 0);
    chk("R1 ready", {31'b0, wr_ready}, 1);
    chk("R1 permit", {31'b0, permit_valid | erase_start}, 0);

    put(17'h01234, 8'h5A);
    chk("R4 unprot grant", {31'b0, permit_valid}, 1);
    chk("R4 unprot addr", {15'b0, permit_addr}, 32'h01234);

    unlock();
    chk("R2 armed", {31'b0, prot_on}, 1);
    chk("R2 no session", {31'b0, page_open}, 0);

    put(17'h00040, 8'h33);
    chk("R6 discard", {31'b0, permit_valid}, 0);

    unlock(17'h18000);
    chk("R11 high bits ignored, R3 open", {31'b0, page_open}, 1);
    put(17'h1A0C1, 8'h77);
    chk("R4 session grant", {31'b0, permit_valid}, 1);
    chk("R11 full addr", {15'b0, permit_addr}, 32'h1A0C1);
    put(17'h1A0C2, 8'h78);

    session_end = 1; @(negedge clk); session_end = 0;
    chk("R5 closed", {31'b0, page_open}, 0);
    chk("R5 prot kept", {31'b0, prot_on}, 1);
    put(17'h1A0C3, 8'h79);
    chk("R5 discard", {31'b0, permit_valid}, 0);

    put(17'h05555, 8'hAA);
    put(17'h00100, 8'h12);
    put(17'h02AAA, 8'h55);
    put(17'h05555, 8'hA0);
    chk("R7 abort", {31'b0, page_open}, 0);
    put(17'h05555, 8'hAA);
    unlock();
    chk("R7 restart", {31'b0, page_open}, 1);

    put(17'h00200, 8'h44, 1);
    chk("R10 write dropped", {31'b0, permit_valid}, 0);
    chk("R10 closed", {31'b0, page_open}, 0);
    put(17'h05555, 8'hAA);
    put(17'h02AAA, 8'h55);
    put(17'h05555, 8'hA0, 1);
    chk("R10 reopen wins", {31'b0, page_open}, 1);

    put(17'h05555, 8'hAA); put(17'h02AAA, 8'h55); put(17'h05555, 8'h80);
    put(17'h05555, 8'hAA); put(17'h02AAA, 8'h55); put(17'h05555, 8'h10);
    chk("R8 erase pulse", {31'b0, erase_start}, 1);
    chk("R8 prot kept", {31'b0, prot_on}, 1);
    chk("R9 stalled", {31'b0, wr_ready}, 0);
    wr_valid = 1; wr_addr = 17'h00300; wr_data = 8'h66;
    repeat (3) begin
      @(negedge clk);
      chk("R9 held not taken", {31'b0, permit_valid}, 0);
    end
    chk("R8 single pulse", {31'b0, erase_start}, 0);
    erase_done = 1; @(negedge clk); erase_done = 0;
    chk("R9 ready back", {31'b0, wr_ready}, 1);
    @(negedge clk); wr_valid = 0;
    chk("R9 held write taken", {31'b0, permit_valid}, 1);
    chk("R9 held data", {24'b0, permit_data}, 32'h66);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule